// File: doc/BRIEF.md
# Interrupt Summary Aggregator

This block gathers the interrupt activity of three groups (receive, transmit and miscellaneous) into one summary cause register and drives a single level interrupt line to the host. Each group presents a single level input that is high while that group has any unmasked cause pending in its own cause bank. The aggregator latches these levels into sticky summary bits. The bits stay set until the host reads the summary register, and that read also clears them.

A separate software mask register sits next to the summary register. The host can silence the whole line with one write of all ones. It re-opens the line by writing a value that clears only the three group bit positions. The interrupt output is a flop. It is high only when a summary bit is set and its mask bit is clear, so the line can never be high while masked.

Top module: `irq_summary_agg`

## Requirements
- R1: After reset the mask register reads all ones, the summary register reads zero and `irq` is low.
- R2: At every rising clock edge, summary bit i is set when `grp_pend[i]` is high. Bit 0 is receive, bit 1 is transmit and bit 2 is miscellaneous. A set bit stays set until a clearing read.
- R3: A read of address 0 (`host_en`=1, `host_we`=0) returns the current summary value on `host_rdata` in the same cycle. All summary bits are cleared at the closing edge of that access, and no acknowledge write is needed.
- R4: A group level that is high in the same cycle as a clearing read is kept in the summary register and is returned by the next read.
- R5: Address 1 is the mask register. A write stores all 32 bits of `host_wdata`. A read returns the stored value and changes nothing.
- R6: After each edge, `irq` is high exactly when some summary bit i is set and mask bit i is clear. With all group mask bits set, `irq` stays low whatever is pending.
- R7: Summary bits 31 down to 3 always read as zero. Writes to address 0 do not change the summary register.
- R8: Addresses 2 and 3 read as zero, and writes to them change neither register.
- R9: `host_rdata` is zero in any cycle that is not a read (`host_en`=0 or `host_we`=1), and such cycles clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_pend | input | 3 | Per-group pending level: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| host_en | input | 1 | Register access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Word address: 0 summary, 1 mask, 2 and 3 unused |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Registered level interrupt to the host |

## Verification
The hardest case to reach from the ports is a group level that rises in the very cycle of a clearing read. It has to survive, and the line has to follow it on the next edge. Random traffic seldom lines these up with a useful mask, so directed steps force the collision for each group in turn. Random cycles then mix reads, mask writes and pending patterns, with the group mask bits biased toward the unmasking value so that `irq` changes often.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;

  localparam int NUM_GRP  = 3;
  localparam int GRP_RX   = 0;
  localparam int GRP_TX   = 1;
  localparam int GRP_MISC = 2;

  typedef enum logic [1:0] {
    REG_CAUSE = 2'd0,
    REG_MASK  = 2'd1,
    REG_SPARE2 = 2'd2,
    REG_SPARE3 = 2'd3
  } reg_sel_e;

  // next value of the sticky summary: clearing read first, then new levels
  function automatic logic [NUM_GRP-1:0] summary_next(
    input logic [NUM_GRP-1:0] cur,
    input logic               clr,
    input logic [NUM_GRP-1:0] pend
  );
    logic [NUM_GRP-1:0] kept;
    kept = clr ? '0 : cur;
    return kept | pend;
  endfunction

  // line level for a summary value and the matching mask bits
  function automatic logic line_level(
    input logic [NUM_GRP-1:0] sum,
    input logic [NUM_GRP-1:0] msk
  );
    return |(sum & ~msk);
  endfunction

endpackage

// File: rtl/irq_sum_latch.sv
module irq_sum_latch
  import irq_sum_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] pend,
  input  logic               clr_rd,
  output logic [NUM_GRP-1:0] sum_d,
  output logic [NUM_GRP-1:0] sum_q
);

  assign sum_d = summary_next(sum_q, clr_rd, pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  // R3 / R4: after a clearing read only the levels of that cycle remain
  a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_rd) && $past(rst_n)) |-> (sum_q == $past(pend)));

  // R2: without a read no set bit falls
  a_r2_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_rd) && $past(rst_n)) |-> ((sum_q & $past(sum_q)) == $past(sum_q)));

  // R2: a high level is always captured
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sum_q & $past(pend)) == $past(pend)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q
);

  assign mask_d = wr_en ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  // R5: a write lands in full
  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n)) |-> (mask_q == $past(wdata)));

  // R5 / R8 / R9: nothing else moves the mask
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(rst_n)) |-> $stable(mask_q));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_sum_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] sum_d,
  input  logic [NUM_GRP-1:0] msk_d,
  input  logic [NUM_GRP-1:0] sum_q,
  input  logic [NUM_GRP-1:0] msk_q,
  output logic               irq
);

  logic line_d;
  assign line_d = line_level(sum_d, msk_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= line_d;
  end

  // R6: the line is never high without an unmasked summary bit
  a_r6_no_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sum_q & ~msk_q) != '0));

  // R6: an unmasked summary bit always shows on the line
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_q & ~msk_q) != '0) |-> irq);

  // R6: all group mask bits set keeps the line low
  a_r6_full_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_q) |-> !irq);

endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
  import irq_sum_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GRP-1:0]  grp_pend,
  input  logic                host_en,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                irq
);

  localparam int PAD_W = DATA_W - NUM_GRP;

  logic rd_acc, wr_acc;
  logic sel_cause, sel_mask;
  logic cause_clr, mask_wr;
  logic [NUM_GRP-1:0] sum_d, sum_q;
  logic [DATA_W-1:0]  mask_d, mask_q;

  assign rd_acc    = host_en && !host_we;
  assign wr_acc    = host_en &&  host_we;
  assign sel_cause = (host_addr == ADDR_W'(REG_CAUSE));
  assign sel_mask  = (host_addr == ADDR_W'(REG_MASK));
  assign cause_clr = rd_acc && sel_cause;
  assign mask_wr   = wr_acc && sel_mask;

  irq_sum_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (grp_pend),
    .clr_rd (cause_clr),
    .sum_d  (sum_d),
    .sum_q  (sum_q)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (host_wdata),
    .mask_d (mask_d),
    .mask_q (mask_q)
  );

  irq_line_gen u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .sum_d (sum_d),
    .msk_d (mask_d[NUM_GRP-1:0]),
    .sum_q (sum_q),
    .msk_q (mask_q[NUM_GRP-1:0]),
    .irq   (irq)
  );

  always_comb begin
    host_rdata = '0;
    if (rd_acc) begin
      if (sel_cause)     host_rdata = {{PAD_W{1'b0}}, sum_q};
      else if (sel_mask) host_rdata = mask_q;
    end
  end

  // R9: only a read drives data
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |-> (host_rdata == '0));

  // R7: padding bits of the summary never read as one
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr |-> (host_rdata[DATA_W-1:NUM_GRP] == '0));

endmodule

// File: tb/irq_summary_agg_bench.sv
module irq_summary_agg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  grp_pend = '0;
  logic        host_en = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0]  m_sum;
  logic [31:0] m_mask;

  always #4 clk = ~clk;

  irq_summary_agg u_irq_summary_agg (
    .clk(clk), .rst_n(rst_n), .grp_pend(grp_pend), .host_en(host_en),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic en, input logic we,
      input logic [1:0] a, input logic [2:0] s, input logic [31:0] m);
    if (!en || we) return 32'h0;
    case (a)
      2'd0:    return {29'h0, s};
      2'd1:    return m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_line(input logic [2:0] s, input logic [31:0] m);
    logic hit = 1'b0;
    for (int i = 0; i < 3; i++) if (s[i] && !m[i]) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check read data, model the edge, check irq
  task automatic step(input logic [2:0] p, input logic en, input logic we,
                      input logic [1:0] a, input logic [31:0] wd, input string tag);
    @(negedge clk);
    grp_pend = p; host_en = en; host_we = we; host_addr = a; host_wdata = wd;
    #1;
    check(host_rdata, exp_read(en, we, a, m_sum, m_mask), {tag, " rdata"});
    if (en && !we && a == 2'd0) m_sum = 3'b000;
    m_sum = m_sum | p;
    if (en && we && a == 2'd1) m_mask = wd;
    @(posedge clk);
    #1;
    check({31'h0, irq}, {31'h0, exp_line(m_sum, m_mask)}, {tag, " irq R6"});
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20251);
    m_sum = 3'b000;
    m_mask = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    step(3'b000, 1, 0, 2'd1, 0, "R1 mask reset");
    step(3'b000, 1, 0, 2'd0, 0, "R1 summary reset");

    // R6: pending while fully masked keeps the line low
    step(3'b111, 0, 0, 2'd0, 0, "R6 masked pend");
    step(3'b000, 0, 0, 2'd0, 0, "R2 hold");
    // R7: writes to summary ignored, padding zero
    step(3'b000, 1, 1, 2'd0, 32'h0, "R7 write cause");
    step(3'b000, 1, 0, 2'd1, 0, "R5 mask read no side effect");
    // R8: spare addresses
    step(3'b000, 1, 1, 2'd2, 32'h0, "R8 write spare2");
    step(3'b000, 1, 1, 2'd3, 32'h0, "R8 write spare3");
    step(3'b000, 1, 0, 2'd2, 0, "R8 read spare2");
    // R9: idle cycle with address 0 clears nothing
    step(3'b000, 0, 0, 2'd0, 0, "R9 idle");
    // R3: clearing read
    step(3'b000, 1, 0, 2'd0, 0, "R3 clearing read");
    step(3'b000, 1, 0, 2'd0, 0, "R3 reads zero after clear");
    // unmask the three group bits only
    step(3'b000, 1, 1, 2'd1, 32'hFFFF_FFF8, "R5 unmask write");
    step(3'b000, 1, 0, 2'd1, 0, "R5 mask readback");
    // R4: collision of each group with a clearing read
    for (int g = 0; g < 3; g++) begin
      step(3'b000, 0, 0, 2'd0, 0, "R2 quiet");
      step(3'(1 << g), 1, 0, 2'd0, 0, "R4 pend during read");
      step(3'b000, 1, 0, 2'd0, 0, "R4 kept for next read");
      step(3'b000, 1, 0, 2'd0, 0, "R3 cleared");
    end
    // R6: one group unmasked at a time
    for (int g = 0; g < 3; g++) begin
      step(3'b000, 1, 1, 2'd1, ~(32'(1) << g), "R5 single unmask");
      step(3'b111, 0, 0, 2'd0, 0, "R2 all pend");
      step(3'b000, 1, 0, 2'd0, 0, "R3 read all");
      step(3'b000, 1, 1, 2'd1, 32'hFFFF_FFFF, "R6 mask all");
    end
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  p;
      logic        en, we;
      logic [1:0]  a;
      logic [31:0] wd;
      p  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      en = ($urandom % 3) != 0;
      we = ($urandom % 4) == 0;
      a  = ($urandom % 3 == 0) ? 2'($urandom) : 2'(($urandom % 2));
      wd = ($urandom % 2) ? ({$urandom} | 32'hFFFF_FFF8) & ~32'(1 << ($urandom % 3))
                          : $urandom;
      step(p, en, we, a, wd, "R2 R3 R5 R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule